// File: doc/BRIEF.md
# Clock Generator Configuration Slave (I2C Block Transfers)

This block is a two-wire serial slave that holds the configuration bank of a system clock generator. A host writes the bank with one block write and reads it back with one block read. The write address is 0xD2 and the read address is 0xD3 (8-bit form, R/W bit included). A write carries two leading bytes that are acknowledged and thrown away: a command code and a byte count. Every byte after those lands in the next register, starting at register 0. A read returns a count byte first and then the registers in order.

SCL and SDA are oversampled by the system clock. SDA is driven only low, through an output-enable. Five strap pins are captured while reset is held. From register 0 the block derives the live control fields: the frequency selection, the spread-spectrum enable and profile, and the output tristate. The frequency selection comes either from the straps or from register bits, depending on a select bit. The bus is meant for standard mode (100 kbit/s or slower) and needs a system clock well above that rate.

Top module: `clkgen_cfg_i2c`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets no acknowledge: SDA stays released in the ninth clock.
- R2: In a write transfer, the first two bytes after the address (command code, byte count) are acknowledged and change no register.
- R3: Data bytes of a write go to registers 0, 1, 2, ... in ascending order, and each is acknowledged. A stop after any complete byte ends the transfer, and the registers already written keep their values. A byte cut short by a stop is discarded.
- R4: A read transfer returns the count byte 6, then registers 0 through 5, MSB first, as long as the master acknowledges. A master no-acknowledge ends the transfer, and SDA is released.
- R5: `freq_sel_o` equals register 0 bits 6:4 when register 0 bit 3 is 1. When bit 3 is 0 it equals strap bits 2:0.
- R6: `ssc_en_o` follows register 0 bit 1 and `tristate_o` follows register 0 bit 0. `ssc_mode_o` is {bit 7, bit 2} of register 0: 00 = ±0.25 % centre, 01 = ±0.15 % centre, 10 = 0 to −0.5 % down, 11 = ±0.375 % centre.
- R7: After reset, register 0 reads 0x10 (bits 6:4 = 001, all else 0), and registers 1 to 6 read 0xFF.
- R8: The strap inputs are sampled while reset is high and held afterwards. Later strap changes have no effect on `strap_q_o` or `freq_sel_o`.
- R9: Data bytes beyond register 6 are acknowledged and change no register.
- R10: A falling SDA while SCL is high is a start condition and a rising SDA while SCL is high is a stop condition. A start inside a transfer (repeated start) begins a new address phase. The block changes SDA only after SCL has gone low, or on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| strap_i | input | 5 | Strap pin levels for power-on configuration |
| cfg_o | output | 56 | All registers, register n in bits 8n+7:8n |
| freq_sel_o | output | 3 | Selected frequency code |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssc_mode_o | output | 2 | Spread profile {reg0[7], reg0[2]} |
| tristate_o | output | 1 | Tristate request for all clock outputs |
| strap_q_o | output | 5 | Latched strap values |

## Verification
Several properties are checked on every cycle. SDA moves only after an SCL fall or a bus condition. Register writes never address past the bank and never occur inside a read transfer. Register 0 bit 0 reaches the tristate output two cycles after a write. The strap latch never changes once reset is released. The bench scenarios cover the rest: the byte contents, the ordering of the sequential load, the discarding of command, count, overflow and partial bytes, and the count-first read sequence. They also cover no-acknowledge on foreign addresses, early master no-acknowledge and repeated starts. Each of these needs a whole bus transaction to show.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BIT,
    ST_WR_ACK,
    ST_RD_BIT,
    ST_RD_ACK
  } xfer_st_t;

  // Power-up contents: register 0 has only the frequency field at 001
  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h10 : 8'hFF;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);

  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_p, sda_p;
  logic scl_n, sda_n;

  assign scl_n = scl_chain[STAGES-1];
  assign sda_n = sda_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      sda_s     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_p     <= scl_n;
      sda_p     <= sda_n;
      scl_rise  <= scl_n & ~scl_p;
      scl_fall  <= ~scl_n & scl_p;
      start_det <= scl_n & scl_p & sda_p & ~sda_n;
      stop_det  <= scl_n & scl_p & ~sda_p & sda_n;
      sda_s     <= sda_n;
    end
  end

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import clkgen_cfg_pkg::*;
#(
  parameter int          NREG     = 7,
  parameter int          RD_COUNT = 6,
  parameter logic [7:0]  WR_ADDR  = 8'hD2,
  parameter logic [7:0]  RD_ADDR  = 8'hD3,
  localparam int         AW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [7:0]    rd_data,
  output logic [7:0]    rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  xfer_st_t    st;
  logic [3:0]  cnt;
  logic [7:0]  sh;
  logic [7:0]  tx;
  logic [7:0]  idx;
  logic        is_rd;
  logic        mack;

  assign rd_addr = idx;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      sda_oe <= 1'b0;
      cnt    <= '0;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (sh == WR_ADDR || sh == RD_ADDR) begin
              st     <= ST_ADDR_ACK;
              sda_oe <= 1'b1;
              is_rd  <= sh[0];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            idx <= '0;
            if (is_rd) begin
              tx     <= 8'(RD_COUNT);
              sda_oe <= ~tx_msb(8'(RD_COUNT));
              st     <= ST_RD_BIT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WR_BIT;
            end
          end
        end
        ST_WR_BIT: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            st     <= ST_WR_ACK;
            sda_oe <= 1'b1;
            if (int'(idx) >= 2 && int'(idx) - 2 < NREG) begin
              wr_en   <= 1'b1;
              wr_addr <= AW'(int'(idx) - 2);
              wr_data <= sh;
            end
            if (idx != 8'hFF) idx <= idx + 8'd1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_WR_BIT;
          end
        end
        ST_RD_BIT: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_RD_ACK;
            end else begin
              cnt    <= cnt + 4'd1;
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              if (idx != 8'hFF) idx <= idx + 8'd1;
              st     <= ST_RD_BIT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  function automatic logic tx_msb(input logic [7:0] b);
    return b[7];
  endfunction

  AST_SDA_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R10

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !is_rd); // R3

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import clkgen_cfg_pkg::*;
#(
  parameter int  NREG = 7,
  parameter int  NSTRAP = 5,
  localparam int AW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTRAP-1:0] strap_i,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_o,
  output logic [2:0]        freq_sel_o,
  output logic              ssc_en_o,
  output logic [1:0]        ssc_mode_o,
  output logic              tristate_o,
  output logic [NSTRAP-1:0] strap_q_o
);

  logic [7:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= reg_default(g);
      else if (wr_en && wr_addr == AW'(g))
        regs[g] <= wr_data;
    end
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (int'(rd_addr) == i) rd_data = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q_o  <= strap_i;
      freq_sel_o <= strap_i[2:0];
      ssc_en_o   <= 1'b0;
      ssc_mode_o <= 2'b00;
      tristate_o <= 1'b0;
    end else begin
      freq_sel_o <= regs[0][3] ? regs[0][6:4] : strap_q_o[2:0];
      ssc_en_o   <= regs[0][1];
      ssc_mode_o <= {regs[0][7], regs[0][2]};
      tristate_o <= regs[0][0];
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> int'(wr_addr) < NREG); // R9

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(strap_q_o)); // R8

  AST_TRISTATE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == '0, 2) |-> tristate_o == $past(wr_data[0], 2)); // R6

endmodule

// File: rtl/clkgen_cfg_i2c.sv
module clkgen_cfg_i2c #(
  parameter int         NREG        = 7,
  parameter int         RD_COUNT    = 6,
  parameter int         SYNC_STAGES = 2,
  parameter int         NSTRAP      = 5,
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NSTRAP-1:0] strap_i,
  output logic [NREG*8-1:0] cfg_o,
  output logic [2:0]        freq_sel_o,
  output logic              ssc_en_o,
  output logic [1:0]        ssc_mode_o,
  output logic              tristate_o,
  output logic [NSTRAP-1:0] strap_q_o
);

  localparam int AW = $clog2(NREG);

  logic          scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, rd_addr, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  i2c_xfer_fsm #(
    .NREG(NREG), .RD_COUNT(RD_COUNT), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) i_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  cfg_regfile #(.NREG(NREG), .NSTRAP(NSTRAP)) i_regs (
    .clk(clk), .rst(rst), .strap_i(strap_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cfg_o(cfg_o), .freq_sel_o(freq_sel_o),
    .ssc_en_o(ssc_en_o), .ssc_mode_o(ssc_mode_o),
    .tristate_o(tristate_o), .strap_q_o(strap_q_o)
  );

endmodule

// File: tb/test_clkgen_cfg_i2c.sv
`timescale 1ns/1ps
module test_clkgen_cfg_i2c;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [4:0] strap = 5'b10101;
  logic sda_oe;
  logic [55:0] cfg;
  logic [2:0] freq_sel;
  logic ssc_en, tristate;
  logic [1:0] ssc_mode;
  logic [4:0] strap_q;
  wire  sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  clkgen_cfg_i2c i_clkgen_cfg_i2c (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .cfg_o(cfg), .freq_sel_o(freq_sel), .ssc_en_o(ssc_en),
    .ssc_mode_o(ssc_mode), .tristate_o(tristate), .strap_q_o(strap_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [7];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops observed read bytes against the expected queue
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), {56'd0, obs_q.pop_front()}, {56'd0, exp_q.pop_front()});
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q/2);
    @(negedge clk) ack_n = sda_bus;
    hold(Q/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl_m = 1'b1; hold(Q/2);
      @(negedge clk) v[i] = sda_bus;
      hold(Q/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0;
    hold(1); sda_m = 1'b1;
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic check_bank(input string tag);
    logic [55:0] e;
    for (int i = 0; i < 7; i++) e[i*8 +: 8] = mdl[i];
    hold(10);
    chk({tag, " bank"}, {8'd0, cfg}, {8'd0, e});
    chk("R5 freq_sel", {61'd0, freq_sel}, {61'd0, mdl[0][3] ? mdl[0][6:4] : 3'b101});
    chk("R6 ssc_en", {63'd0, ssc_en}, {63'd0, mdl[0][1]});
    chk("R6 ssc_mode", {62'd0, ssc_mode}, {62'd0, mdl[0][7], mdl[0][2]});
    chk("R6 tristate", {63'd0, tristate}, {63'd0, mdl[0][0]});
  endtask

  // block write: header then n data bytes; every byte must be acknowledged
  task automatic wr_block(input logic [7:0] d [12], input int n, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk("R1 write address ack", {63'd0, a}, 64'd0);
    send_byte(8'h77, a); chk("R2 command ack", {63'd0, a}, 64'd0);
    send_byte(8'h33, a); chk("R2 count ack", {63'd0, a}, 64'd0);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      chk(tag, {63'd0, a}, 64'd0);
      if (i < 7) mdl[i] = d[i];
    end
  endtask

  task automatic finish_run();
    hold(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] v;
    logic [7:0] d [12];
    mdl[0] = 8'h10;
    for (int i = 1; i < 7; i++) mdl[i] = 8'hFF;
    hold(6);
    rst = 1'b0;
    hold(2);
    strap = 5'b01010;

    // R7 reset contents, R8 strap capture
    check_bank("R7 reset");
    chk("R8 strap latch", {59'd0, strap_q}, {59'd0, 5'b10101});

    // R1 foreign address gets no acknowledge
    bus_start();
    send_byte(8'hA0, a); chk("R1 foreign address nack", {63'd0, a}, 64'd1);
    bus_stop();
    check_bank("R1 no change");

    // R2/R3 ordinary block write of two registers
    d[0] = 8'hBE; d[1] = 8'h5A;
    wr_block(d, 2, "R3 data ack");
    bus_stop();
    check_bank("R3 two-byte write");

    // R3 partial byte before stop is discarded; R5 strap path, R8 ignore new straps
    d[0] = 8'h01;
    wr_block(d, 1, "R3 data ack");
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    bus_stop();
    check_bank("R3 partial byte");
    chk("R8 strap held", {59'd0, strap_q}, {59'd0, 5'b10101});

    // R9 overflow bytes acknowledged and ignored
    for (int i = 0; i < 10; i++) d[i] = 8'h20 + 8'(i);
    wr_block(d, 10, "R9 data ack");
    bus_stop();
    check_bank("R9 overflow");

    // R4 full block read: count then registers 0..5
    bus_start();
    send_byte(8'hD3, a); chk("R1 read address ack", {63'd0, a}, 64'd0);
    expect_byte("R4 count byte", 8'd6);
    recv_byte(1'b1, v); obs_q.push_back(v);
    for (int i = 0; i < 6; i++) begin
      expect_byte("R4 register byte", mdl[i]);
      recv_byte(i != 5, v); obs_q.push_back(v);
    end
    bus_stop();

    // R4 early master nack, then the bus still works
    bus_start();
    send_byte(8'hD3, a);
    expect_byte("R4 count before nack", 8'd6);
    recv_byte(1'b0, v); obs_q.push_back(v);
    hold(Q);
    chk("R4 sda released after nack", {63'd0, sda_oe}, 64'd0);
    bus_stop();

    // R10 repeated start from write into read
    d[0] = 8'hC9;
    wr_block(d, 1, "R10 data ack");
    bus_start();
    send_byte(8'hD3, a); chk("R10 repeated start address ack", {63'd0, a}, 64'd0);
    expect_byte("R10 count after repeated start", 8'd6);
    recv_byte(1'b1, v); obs_q.push_back(v);
    expect_byte("R10 reg0 after repeated start", 8'hC9);
    recv_byte(1'b0, v); obs_q.push_back(v);
    bus_stop();
    check_bank("R10 after repeated start");

    hold(20);
    chk("R4 scoreboard drained", {32'd0, 32'(exp_q.size())}, 64'd0);
    finish_run();
  end

endmodule